// File: doc/BRIEF.md
# Row-Saturating Nested Array Accumulator

This block adds up a small two-dimensional array of signed words and returns one total. A single start pulse captures the whole array from a flat packed input vector. The block then walks the elements one per clock cycle, row by row. Row and column stepping are folded into one flattened counter, so there is no dead cycle between rows.

At the first element of every row, the running total is first limited to a ceiling value. That limited value then feeds the add for that element in the same cycle. The limit acts only at row entry. The total after the last row is passed out unchanged and may lie above the ceiling. Negative totals are never altered.

When the last add has been made, a one-cycle done pulse marks the result as valid. The result stays on the output until the next accepted start.

Top module: `row_sat_accum`

## Requirements
- R1: After reset, `done_o` is 0 and `result_o` is 0.
- R2: A `start_i` pulse while the block is idle captures `din_i`. Element (row r, column c) sits at bits [(r*COLS+c)*WIDTH +: WIDTH], so element 0 is in the lowest bits. Elements are summed from a zero total.
- R3: Elements are added one per cycle in row-major order. All ROWS*COLS adds run on consecutive cycles with no gap between rows.
- R4: At the first element of each row, a total strictly greater than LIMIT (default 100000) is replaced by LIMIT before that element is added. A total exactly equal to LIMIT is left as it is.
- R5: The comparison is signed, so a negative total is never replaced.
- R6: The total after the last row is output without any clamp and may exceed LIMIT.
- R7: `done_o` goes high for exactly one cycle. It rises on the ROWS*COLS-th clock edge after the edge that accepted the start, which is the edge of the final add.
- R8: `result_o` holds its value from the done pulse until the next accepted start.
- R9: A `start_i` pulse that arrives while a pass is in progress is ignored. The pass continues on the data first captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a pass; accepted only when idle |
| din_i | input | ROWS*COLS*WIDTH | Packed array, row-major, element 0 in the low bits |
| result_o | output | WIDTH | Signed total |
| done_o | output | 1 | One-cycle valid pulse for `result_o` |

## Verification
Several properties are checked on every cycle. The assertions confirm that done lasts a single cycle and comes only after the final index. They confirm that a start arriving during a pass does not reset the index, and that the total stays still while idle. They also check, at each row entry, that the total is replaced by the ceiling only when it lies above it. The correctness of the sum itself needs the bench scenarios. These cover clamped, unclamped, boundary-equal and negative row totals, an unclamped final total above the ceiling, and a start issued during a pass. Each is compared against an arithmetic model.

// File: rtl/row_sat_accum_pkg.sv
// Package: shared sizing defaults for the row-saturating accumulator.
// Assumes: the array is small enough that one pass fits in a plain counter.
package row_sat_accum_pkg;
    localparam int DEF_ROWS  = 2;
    localparam int DEF_COLS  = 4;
    localparam int DEF_WIDTH = 32;
    localparam int DEF_LIMIT = 100000;
endpackage

// File: rtl/row_sat_accum_seq.sv
// Module: flattened row/column sequencer.
// Steps one index per cycle over ROWS*COLS elements. It flags the first
// column of each row and pulses done on the edge of the last step.
// Assumes: start is ignored while a pass runs.
module row_sat_accum_seq #(
    parameter int ROWS = 2,
    parameter int COLS = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start_i,
    output logic                             load_o,
    output logic                             busy_o,
    output logic [$clog2(ROWS*COLS+1)-1:0]   idx_o,
    output logic                             row_first_o,
    output logic                             done_o
);
    localparam int NELEM = ROWS * COLS;
    localparam int IDXW  = $clog2(NELEM + 1);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NELEM - 1);

    logic [IDXW-1:0] idx_q;
    logic            busy_q;
    logic            done_q;
    logic            last;

    assign load_o      = start_i && !busy_q;
    assign busy_o      = busy_q;
    assign idx_o       = idx_q;
    assign last        = (idx_q == LAST_IDX);
    assign row_first_o = ((int'(idx_q) % COLS) == 0);
    assign done_o      = done_q;

    // Advance the flat index and track the busy window of a pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load_o) begin
                busy_q <= 1'b1;
                idx_q  <= '0;
            end else if (busy_q) begin
                idx_q <= idx_q + 1'b1;
                if (last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R7
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> ($past(busy_q) && $past(idx_q) == LAST_IDX)); // R7
    AST_PASS_BEGINS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> idx_q == '0); // R3
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_q && !last) |=> (busy_q && idx_q == $past(idx_q) + 1'b1)); // R9
endmodule

// File: rtl/row_sat_accum_dp.sv
// Module: capture register, row-entry clamp and adder.
// On load it stores the array and clears the total. While busy it adds the
// indexed element. At the first column the total is first limited to LIMIT.
// Assumes: no wrap within a pass (sums stay inside WIDTH bits).
module row_sat_accum_dp #(
    parameter int ROWS  = 2,
    parameter int COLS  = 4,
    parameter int WIDTH = 32,
    parameter int LIMIT = 100000
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             load_i,
    input  logic                             busy_i,
    input  logic [$clog2(ROWS*COLS+1)-1:0]   idx_i,
    input  logic                             row_first_i,
    input  logic [ROWS*COLS*WIDTH-1:0]       din_i,
    output logic signed [WIDTH-1:0]          acc_o
);
    localparam int NELEM = ROWS * COLS;
    localparam logic signed [WIDTH-1:0] CEIL = WIDTH'(LIMIT);

    logic [NELEM*WIDTH-1:0]   data_q;
    logic signed [WIDTH-1:0]  acc_q;
    logic signed [WIDTH-1:0]  elem;
    logic signed [WIDTH-1:0]  base;

    assign elem  = $signed(data_q[int'(idx_i)*WIDTH +: WIDTH]);
    assign acc_o = acc_q;

    // Pick the addend base: the clamped total at row entry, else the total.
    always_comb begin
        base = acc_q;
        if (row_first_i && (acc_q > CEIL)) base = CEIL;
    end

    // Capture the array on load; accumulate one element per busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            acc_q  <= '0;
        end else if (load_i) begin
            data_q <= din_i;
            acc_q  <= '0;
        end else if (busy_i) begin
            acc_q <= base + elem;
        end
    end

    AST_CLAMP_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !load_i && row_first_i && acc_q > CEIL) |=> acc_q == CEIL + $past(elem)); // R4
    AST_NEG_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !load_i && acc_q < 0) |=> acc_q == $past(acc_q) + $past(elem)); // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && !load_i) |=> $stable(acc_q)); // R8
    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> acc_q == '0); // R2
endmodule

// File: rtl/row_sat_accum.sv
// Module: top of the row-saturating nested array accumulator.
// Joins the flattened sequencer with the clamp/add datapath. The result is
// the running total register, valid while done_o pulses and held afterwards.
// Assumes: start_i is a pulse; repeats during a pass are dropped.
module row_sat_accum
    import row_sat_accum_pkg::*;
#(
    parameter int ROWS  = DEF_ROWS,
    parameter int COLS  = DEF_COLS,
    parameter int WIDTH = DEF_WIDTH,
    parameter int LIMIT = DEF_LIMIT
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [ROWS*COLS*WIDTH-1:0]  din_i,
    output logic [WIDTH-1:0]            result_o,
    output logic                        done_o
);
    localparam int IDXW = $clog2(ROWS * COLS + 1);

    logic            load;
    logic            busy;
    logic [IDXW-1:0] idx;
    logic            row_first;
    logic signed [WIDTH-1:0] acc;

    row_sat_accum_seq #(.ROWS(ROWS), .COLS(COLS)) seq_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .load_o(load),
        .busy_o(busy), .idx_o(idx), .row_first_o(row_first), .done_o(done_o)
    );

    row_sat_accum_dp #(.ROWS(ROWS), .COLS(COLS), .WIDTH(WIDTH), .LIMIT(LIMIT)) dp_i (
        .clk(clk), .rst_n(rst_n), .load_i(load), .busy_i(busy), .idx_i(idx),
        .row_first_i(row_first), .din_i(din_i), .acc_o(acc)
    );

    assign result_o = acc;

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> $stable(result_o)); // R8
endmodule

// File: tb/row_sat_accum_tb_top.sv
module row_sat_accum_tb_top;
    localparam int ROWS = 2, COLS = 4, W = 32, LIM = 100000;
    localparam int N = ROWS * COLS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [N*W-1:0] din = '0;
    logic [W-1:0] result;
    logic done;
    int checks = 0, fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    row_sat_accum #(.ROWS(ROWS), .COLS(COLS), .WIDTH(W), .LIMIT(LIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .din_i(din),
        .result_o(result), .done_o(done)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint model(input logic [N*W-1:0] v);
        longint acc = 0;
        for (int r = 0; r < ROWS; r++) begin
            if (acc > LIM) acc = LIM;
            for (int c = 0; c < COLS; c++)
                acc += longint'($signed(v[(r*COLS+c)*W +: W]));
        end
        return acc;
    endfunction

    // One pass; optionally pulse start with other data at step busy_at.
    task automatic run(input logic [N*W-1:0] v, input int busy_at,
                       input logic [N*W-1:0] other, input string req);
        int seen = -1;
        longint exp = model(v);
        @(negedge clk); start = 1'b1; din = v;
        @(negedge clk); start = 1'b0;
        for (int i = 1; i <= N + 2; i++) begin
            if (i == busy_at) begin start = 1'b1; din = other; end
            @(negedge clk);
            start = 1'b0;
            if (done && seen < 0) begin
                seen = i;
                chk({req, " R7 latency"}, i, N);
                chk({req, " value"}, longint'($signed(result)), exp);
            end else if (seen >= 0 && i == seen + 1) begin
                chk("R7 single cycle", done, 0);
                chk("R8 hold", longint'($signed(result)), exp);
            end
        end
        if (seen < 0) chk({req, " R7 no done"}, 0, 1);
    endtask

    function automatic logic [N*W-1:0] pack(input int e[N]);
        logic [N*W-1:0] v;
        for (int i = 0; i < N; i++) v[i*W +: W] = W'(e[i]);
        return v;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 done", done, 0);
        chk("R1 result", result, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run(pack('{1, 2, 3, 4, 5, 6, 7, 8}), 0, '0, "R2 R3 ramp");
        run(pack('{50000, 30000, 20000, 10000, 1, 2, 3, 4}), 0, '0, "R4 clamp");
        run(pack('{50000, 50000, 0, 0, 7, 0, 0, 0}), 0, '0, "R4 equal limit");
        run(pack('{50000, 50001, 0, 0, 7, 0, 0, 0}), 0, '0, "R4 limit plus one");
        run(pack('{-90000, -90000, 5, 5, 10, 10, 10, 10}), 0, '0, "R5 negative");
        run(pack('{100, 0, 0, 0, 90000, 90000, 90000, 90000}), 0, '0, "R6 final over");
        run(pack('{2000000, 0, 0, 0, 90000, 90000, 90000, 90000}), 0, '0, "R4 R6 both");
        run(pack('{1, 1, 1, 1, 1, 1, 1, 1}), 3, pack('{9, 9, 9, 9, 9, 9, 9, 9}), "R9 busy start");
        run(pack('{10, 20, 30, 40, 50, 60, 70, 80}), N, pack('{1, 1, 1, 1, 1, 1, 1, 1}), "R9 last step start");
        for (int k = 0; k < 60; k++) begin
            int e[N];
            for (int i = 0; i < N; i++)
                e[i] = ((k * 7919 + i * 104729 + k * i * 31) % 160001) - 50000;
            run(pack(e), 0, '0, "R2 R3 R4 R5 R6 sweep");
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule